// File: doc/BRIEF.md
# Serial Sample Deserializer with Test-Pattern Word Alignment

This block turns the double-data-rate serial stream of one converter channel into parallel 12-bit sample words. The bit clock has already been sampled on both of its edges upstream, so the block takes in a pair of bits on every clock. It collects six pairs into one word. Bits travel least significant first.

The word boundary is set in one of two ways.

- **Normal data mode:** a frame marker sent with a pair marks that pair as the start of a word.
- **Test-pattern mode:** the converter sends a fixed word. The block compares every completed word against that known value. On a mismatch it moves its boundary one bit later and keeps doing so until the words match. A lock flag reports stable alignment. An error flag reports the most recent mismatch.

A multi-channel converter needs one instance per channel.

Top module: `adc_deser_align`

## Requirements
- R1: `bit_pair[0]` is the earlier bit of a pair and `bit_pair[1]` the later. The first bit received of a word becomes bit 0 of `word_out`, so pair i of a word fills bits 2i and 2i+1.
- R2: In normal mode, a pair sent with `frame_mark` high is pair 0 of a new word. On the clock after the sixth pair is sampled, `word_valid` is high for one cycle and `word_out` carries the word. `word_out` holds its value while `word_valid` is low.
- R3: With no slip and no marker, `word_valid` pulses exactly once every 6 clocks.
- R4: The `mode` codes are as follows. Code 01 selects the alternating pattern, expected word 12'h555 (binary 010101010101). Code 10 selects the split pattern, expected word 12'hFC0 (six ones above six zeros). Codes 00 and 11 select normal data.
- R5: In a pattern mode, a completed word that differs from the expected word has three effects. The boundary moves one bit later for the next word. `slip_cnt` advances by one and wraps from 11 to 0. The run of matches restarts from zero.
- R6: `locked` rises with the fourth consecutive matching word.
- R7: `locked` falls with the second consecutive mismatching word. A single mismatch leaves it high.
- R8: In a pattern mode, `pat_err` goes high with a mismatching word. It stays high until the next completed word, which clears it if that word matches.
- R9: In normal mode there is no pattern checking. `pat_err` is 0, while `locked` and `slip_cnt` keep the values they had.
- R10: A synchronous active-low `rst_n` clears the word, the strobe, `slip_cnt`, the match counters, `locked` and `pat_err`.
- R11: `frame_mark` has no effect in a pattern mode. In normal mode, a marker also returns `slip_cnt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_pair | input | 2 | Two serial bits, [0] earlier |
| frame_mark | input | 1 | Start-of-word marker (normal mode) |
| mode | input | 2 | 00/11 data, 01 alternating, 10 split |
| word_out | output | 12 | Last completed word |
| word_valid | output | 1 | One-cycle strobe per completed word |
| slip_cnt | output | 4 | Bit slips taken, modulo 12 |
| locked | output | 1 | Alignment locked |
| pat_err | output | 1 | Last pattern word mismatched |

## Verification
The assertions run on every cycle and check the following rules:
- `word_valid` never lasts two cycles, and `word_out` holds between strobes.
- The phase counter stays within its legal states.
- `slip_cnt` only ever advances by one or returns to zero.
- `locked` rises only on a matching word and falls only on a mismatch that follows an earlier one.
- `pat_err` appears only while a pattern mode is selected.

Only the bench scenarios can show the rest. They sweep every starting bit offset of both patterns and check, word by word, that the block takes the right number of slips and locks at the right word. They also cover loss of lock, lock hold in normal mode, and correct LSB-first bit placement under marker framing.

// File: rtl/adc_deser_pkg.sv
// Shared mode encoding for the serial deserializer.
// Assumes the 2-bit mode word is applied directly from a configuration register.
package adc_deser_pkg;

    typedef enum logic [1:0] {
        MODE_DATA  = 2'b00,
        MODE_ALT   = 2'b01,
        MODE_SPLIT = 2'b10,
        MODE_DATA2 = 2'b11
    } mode_e;

    // True when the mode selects one of the two test patterns.
    function automatic logic is_pat_mode(input logic [1:0] m);
        return (m == MODE_ALT) || (m == MODE_SPLIT);
    endfunction

endpackage

// File: rtl/adc_word_framer.sv
// Collects bit pairs into candidate words and tracks the word boundary.
// Assumes WORD is even. A bit window of WORD+1 bits plus a one-bit offset
// allows single-bit slips while the input arrives two bits per clock.
module adc_word_framer #(
    parameter int WORD = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bit_pair,
    input  logic            mark_take,
    input  logic            slip_req,
    output logic [WORD-1:0] cand_word,
    output logic            cand_done
);
    localparam int PAIRS = WORD / 2;
    localparam int PH_W  = $clog2(PAIRS) + 1;
    localparam int SR_W  = WORD + 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAIRS - 1);
    localparam logic [PH_W-1:0] PH_HOLD = '1;

    logic [SR_W-1:0] sreg;
    logic [SR_W-1:0] sreg_nx;
    logic [PH_W-1:0] ph;
    logic            off;

    // New pair enters at the top; the older bit sits lower.
    always_comb begin
        sreg_nx   = {bit_pair[1], bit_pair[0], sreg[SR_W-1:2]};
        cand_done = (ph == PH_LAST) && !mark_take;
        cand_word = off ? sreg_nx[WORD-1:0] : sreg_nx[WORD:1];
    end

    // Shift window, pair phase and bit offset update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            ph   <= '0;
            off  <= 1'b0;
        end else begin
            sreg <= sreg_nx;
            if (mark_take) begin
                ph  <= PH_W'(1);
                off <= 1'b0;
            end else if (cand_done) begin
                if (slip_req && !off) begin
                    ph  <= PH_HOLD;
                    off <= 1'b1;
                end else begin
                    ph  <= '0;
                    off <= slip_req ? 1'b0 : off;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph <= PH_LAST) || (ph == PH_HOLD));

endmodule

// File: rtl/adc_pattern_monitor.sv
// Compares completed words against the selected test pattern. It requests
// slips and keeps the slip count, the lock state and the error flag.
// Assumes mode changes are rare compared with the word rate.
module adc_pattern_monitor
    import adc_deser_pkg::*;
#(
    parameter int WORD     = 12,
    parameter int LOCK_N   = 4,
    parameter int UNLOCK_N = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode,
    input  logic [WORD-1:0]          cand_word,
    input  logic                     cand_done,
    input  logic                     mark_take,
    output logic                     slip_req,
    output logic [$clog2(WORD)-1:0]  slip_cnt,
    output logic                     locked,
    output logic                     pat_err
);
    localparam int SC_W = $clog2(WORD);
    localparam int MC_W = $clog2(LOCK_N + 1);
    localparam int EC_W = $clog2(UNLOCK_N + 1);

    logic [WORD-1:0] alt_pat;
    logic [WORD-1:0] split_pat;
    logic [WORD-1:0] exp_word;
    logic [MC_W-1:0] match_cnt;
    logic [EC_W-1:0] mis_cnt;
    logic            is_pat;
    logic            hit;

    // Build both reference words and pick the one the mode asks for.
    always_comb begin
        for (int i = 0; i < WORD; i++) begin
            alt_pat[i]   = ((i % 2) == 0);
            split_pat[i] = (i >= WORD / 2);
        end
        is_pat   = is_pat_mode(mode);
        exp_word = (mode == MODE_ALT) ? alt_pat : split_pat;
        hit      = (cand_word == exp_word);
        slip_req = is_pat && cand_done && !hit;
    end

    // Match/mismatch runs, lock, slip count and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_cnt <= '0;
            mis_cnt   <= '0;
            slip_cnt  <= '0;
            locked    <= 1'b0;
            pat_err   <= 1'b0;
        end else if (!is_pat) begin
            pat_err <= 1'b0;
            if (mark_take) slip_cnt <= '0;
        end else if (cand_done) begin
            if (hit) begin
                mis_cnt <= '0;
                pat_err <= 1'b0;
                if (match_cnt < MC_W'(LOCK_N)) match_cnt <= match_cnt + 1'b1;
                if (match_cnt >= MC_W'(LOCK_N - 1)) locked <= 1'b1;
            end else begin
                match_cnt <= '0;
                pat_err   <= 1'b1;
                slip_cnt  <= (slip_cnt == SC_W'(WORD - 1)) ? '0 : slip_cnt + 1'b1;
                if (mis_cnt < EC_W'(UNLOCK_N)) mis_cnt <= mis_cnt + 1'b1;
                if (mis_cnt >= EC_W'(UNLOCK_N - 1)) locked <= 1'b0;
            end
        end
    end

    p_slip_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_cnt != $past(slip_cnt)) |-> (slip_cnt == '0 || slip_cnt == $past(slip_cnt) + 1'b1));

    p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(cand_done) && !pat_err));

    p_lock_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (pat_err && $past(mis_cnt) >= EC_W'(UNLOCK_N - 1)));

    p_err_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pat_err |-> $past(is_pat));

endmodule

// File: rtl/adc_deser_align.sv
// One-channel serial-to-parallel deserializer with test-pattern alignment.
// Assumes a pre-sampled DDR pair on every clock, [0] the earlier bit, LSB first.
// Instantiate once per converter channel.
module adc_deser_align
    import adc_deser_pkg::*;
#(
    parameter int WORD     = 12,
    parameter int LOCK_N   = 4,
    parameter int UNLOCK_N = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              bit_pair,
    input  logic                    frame_mark,
    input  logic [1:0]              mode,
    output logic [WORD-1:0]         word_out,
    output logic                    word_valid,
    output logic [$clog2(WORD)-1:0] slip_cnt,
    output logic                    locked,
    output logic                    pat_err
);
    logic [WORD-1:0] cand_word;
    logic            cand_done;
    logic            slip_req;
    logic            mark_take;

    // Markers only frame words in normal data mode.
    assign mark_take = frame_mark && !is_pat_mode(mode);

    adc_word_framer #(.WORD(WORD)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_pair  (bit_pair),
        .mark_take (mark_take),
        .slip_req  (slip_req),
        .cand_word (cand_word),
        .cand_done (cand_done)
    );

    adc_pattern_monitor #(.WORD(WORD), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cand_word (cand_word),
        .cand_done (cand_done),
        .mark_take (mark_take),
        .slip_req  (slip_req),
        .slip_cnt  (slip_cnt),
        .locked    (locked),
        .pat_err   (pat_err)
    );

    // Register the completed word and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= cand_done;
            if (cand_done) word_out <= cand_word;
        end
    end

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

endmodule

// File: tb/tb_adc_deser_align.sv
module tb_adc_deser_align;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bit_pair;
    logic        frame_mark;
    logic [1:0]  mode;
    logic [11:0] word_out;
    logic        word_valid;
    logic [3:0]  slip_cnt;
    logic        locked;
    logic        pat_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int last_v  = 0;
    int gap     = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    adc_deser_align dut (
        .clk(clk), .rst_n(rst_n), .bit_pair(bit_pair), .frame_mark(frame_mark),
        .mode(mode), .word_out(word_out), .word_valid(word_valid),
        .slip_cnt(slip_cnt), .locked(locked), .pat_err(pat_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one pair, wait one edge, sample 1 ns later.
    task automatic push(input logic b0, input logic b1, input logic fm);
        bit_pair   = {b1, b0};
        frame_mark = fm;
        @(posedge clk);
        #1;
        cyc++;
        if (word_valid) begin
            gap    = cyc - last_v;
            last_v = cyc;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode  = 2'b00;
        repeat (3) push(1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        chk("R10 word_valid", word_valid, 0);
        chk("R10 word_out", word_out, 0);
        chk("R10 slip_cnt", slip_cnt, 0);
        chk("R10 locked", locked, 0);
        chk("R10 pat_err", pat_err, 0);
    endtask

    function automatic logic [11:0] pat_of(input int m);
        return (m == 1) ? 12'h555 : 12'hFC0;
    endfunction

    function automatic logic pbit(input int m, input int d, input int idx);
        logic [11:0] p;
        p = pat_of(m);
        return p[(idx + d) % 12];
    endfunction

    // Pattern stream starting at bit offset d. Markers are sprinkled in to show they are ignored (R11).
    task automatic run_align(input int m, input int d);
        int s;
        int k;
        int w;
        s = (m == 1) ? (d % 2) : ((12 - d) % 12);
        do_reset();
        mode = m[1:0];
        k = 0;
        w = 0;
        while (w < s + 6) begin
            push(pbit(m, d, k), pbit(m, d, k + 1), (k % 10) == 4);
            k += 2;
            if (word_valid) begin
                w++;
                chk("R8 pat_err per word", pat_err, (w <= s) ? 1 : 0);
                chk("R5/R11 slip_cnt", slip_cnt, (w < s) ? w : s);
                chk("R6 locked per word", locked, (w >= s + 4) ? 1 : 0);
            end
        end
        chk("R4 aligned word", word_out, pat_of(m));
        chk("R3 strobe spacing", gap, 6);
    endtask

    task automatic next_zero_word();
        do push(1'b0, 1'b0, 1'b0); while (!word_valid);
    endtask

    // Normal-mode word framed by a marker on its first pair.
    task automatic send_word(input logic [11:0] w, input int junk);
        for (int j = 0; j < junk; j++) push(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            push(w[2*i], w[2*i+1], i == 0);
            if (i == 4) chk("R2 no early strobe", word_valid, 0);
        end
        chk("R2 strobe after sixth pair", word_valid, 1);
        chk("R1 LSB-first word", word_out, w);
    endtask

    initial begin
        rst_n = 1'b0;
        bit_pair = 2'b00;
        frame_mark = 1'b0;
        mode = 2'b00;

        // Exhaustive offset sweep for both patterns.
        for (int m = 1; m <= 2; m++)
            for (int d = 0; d < 12; d++)
                run_align(m, d);

        // Loss of lock: split pattern locked, then a constant-zero stream.
        run_align(2, 5);
        next_zero_word();
        chk("R7 one mismatch keeps lock", locked, 1);
        chk("R8 error on mismatch", pat_err, 1);
        next_zero_word();
        chk("R7 two mismatches drop lock", locked, 0);
        chk("R8 error held", pat_err, 1);

        // Normal mode holds lock and clears error, for both data codes.
        for (int c = 0; c < 2; c++) begin
            run_align(2, 0);
            mode = (c == 0) ? 2'b00 : 2'b11;
            for (int n = 0; n < 3; n++) next_zero_word();
            chk("R9 locked held", locked, 1);
            chk("R9 pat_err low", pat_err, 0);
            chk("R9 slip_cnt held", slip_cnt, 0);
        end

        // Marker framing in normal mode, codes 00 and 11, with junk pairs between words.
        for (int c = 0; c < 2; c++) begin
            do_reset();
            mode = (c == 0) ? 2'b00 : 2'b11;
            for (int i = 0; i < 10; i++)
                send_word(12'((i * 32'h9A7 + 32'h13 + c * 32'h5C) & 32'hFFF), i % 4);
            chk("R9 pat_err normal", pat_err, 0);
        end

        // A marker in normal mode returns the slip count to zero.
        run_align(2, 7);
        mode = 2'b00;
        send_word(12'hA3C, 0);
        chk("R11 marker clears slip_cnt", slip_cnt, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule